// File: doc/BRIEF.md
# Tag Memory with Match Comparator

This block is a synchronous tag store with a built-in equality comparator, meant to sit beside a cache controller that asks one question per clock: does the tag held at this index equal the tag I have now? Every control input is sampled on the rising clock edge. The sampled controls select one of five operations: deselect, read, write, compare or fill. A compare reads the stored word at the sampled index while the data outputs stay off. In the same edge it captures the key from the write-data bus into an input register. It then produces a single match flag. A fill writes the key already held in that register into the array, so a miss can be repaired on the next clock without presenting the tag again.

The match flag and the read data share one timing-mode pin. In flow-through mode the result appears in the cycle after the sampling edge. In pipelined mode it appears one cycle later, from a register. The match output has its own drive-enable, separate from the data drive-enable. Both enables follow their enable inputs without waiting for a clock. Tri-state pins are modelled as a value plus a drive-enable, so the block can be placed inside an FPGA fabric.

Top module: `tag_match_ram`

## Requirements
- R1: While `rst` is high on a clock edge, the match register clears to 0 (no match) and the data-valid state clears. After reset, `match_o` reads 0 in both modes and `rdata_oe_o` is 0.
- R2: The operation is decoded from the inputs sampled at the clock edge. With `sel_i`=1, `wr_i`=1 and `din_en_i`=1, the edge stores `wdata_i` at `addr_i`. With `sel_i`=1, `wr_i`=0 and `out_en_i`=1, the edge reads `addr_i`, and that stored word is presented on `rdata_o`.
- R3: With `sel_i`=1, `wr_i`=0, `out_en_i`=0 and `din_en_i`=1, the edge performs a compare. `wdata_i` is captured as the key and the stored word at `addr_i` is read. `match_o` is 1 only if all DATA_W bits are equal, so any single differing bit, including bit 0 or bit DATA_W-1, gives 0.
- R4: With `ft_mode_i`=1, a compare or read result is visible during the cycle right after its sampling edge. With `ft_mode_i`=0, the result is visible during the cycle after the next edge.
- R5: With `sel_i`=1, `wr_i`=1 and `din_en_i`=0, the edge performs a fill. The key register content is written to `addr_i`, and the match flag keeps its previous value through the fill.
- R6: An edge with `sel_i`=0 (deselect) sets the match result to 1, with the same latency as a compare.
- R7: `match_oe_o` equals `mat_en_i` at all times. It is not clocked and does not depend on the operation.
- R8: `rdata_oe_o` is 1 only while `out_en_i` is 1 and the output stage selected by the timing mode holds a read. Compare, fill, write and deselect cycles never drive data.
- R9: A new compare can be issued every clock. A hit, a miss and a fill on consecutive clocks each produce their own result without interference.
- R10: The key register is updated only on edges with `din_en_i`=1. A read with `din_en_i`=0 leaves the key unchanged, which is observed through a later fill and read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ft_mode_i | input | 1 | 1 = flow-through results, 0 = pipelined results |
| sel_i | input | 1 | Block select, active high |
| wr_i | input | 1 | Write request, active high |
| out_en_i | input | 1 | Data output enable, active high; also part of the decode |
| din_en_i | input | 1 | Key/data input register enable, active high |
| mat_en_i | input | 1 | Match output enable, active high, asynchronous |
| addr_i | input | ADDR_W | Tag index |
| wdata_i | input | DATA_W | Write data or compare key |
| rdata_o | output | DATA_W | Read data value |
| rdata_oe_o | output | 1 | Drive-enable for rdata_o |
| match_o | output | 1 | Match flag value |
| match_oe_o | output | 1 | Drive-enable for match_o |

## Verification
The array is first loaded with a distinct pattern at every index. Compares are then issued with the exact stored tag and with keys that differ only in the top bit or only in the bottom bit. These cases separate a full-width comparator from one that ignores an edge bit. Hit, miss, fill, compare runs are issued back to back in both timing modes. Deselect, reads with the key register disabled, and enable toggling are interleaved with them. This shows whether latency, flag holding and key capture are tied to the right edge. A long stretch of random operations over all indices is then compared each cycle against a behavioural model, which catches decode-priority and stage-mixing errors.

// File: rtl/tagcmp_pkg.sv
package tagcmp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_DESEL = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_CMP   = 3'd4,
    OP_FILL  = 3'd5
  } op_e;
endpackage

// File: rtl/tagcmp_decode.sv
module tagcmp_decode
  import tagcmp_pkg::*;
(
  input  logic sel_i,
  input  logic wr_i,
  input  logic out_en_i,
  input  logic din_en_i,
  output op_e  op_o
);
  always_comb begin
    if (!sel_i)
      op_o = OP_DESEL;
    else if (wr_i)
      op_o = din_en_i ? OP_WRITE : OP_FILL;
    else if (!out_en_i && din_en_i)
      op_o = OP_CMP;
    else
      op_o = OP_READ;
  end
endmodule

// File: rtl/tagcmp_array.sv
module tagcmp_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // read-first single-port memory, block RAM inferable
  always_ff @(posedge clk) begin
    if (we_i)
      store[addr_i] <= wdata_i;
    rdata_o <= store[addr_i];
  end
endmodule

// File: rtl/tagcmp_match.sv
module tagcmp_match
  import tagcmp_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ft_mode_i,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] stored_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              match_o,
  output logic              held_o
);
  logic hit;
  logic result_ft;
  logic held_q;

  assign hit = (stored_i == key_i);

  always_comb begin
    unique case (op_i)
      OP_CMP:   result_ft = hit;
      OP_DESEL: result_ft = 1'b1;
      default:  result_ft = held_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      held_q <= 1'b0;
    else
      held_q <= result_ft;
  end

  assign held_o  = held_q;
  assign match_o = ft_mode_i ? result_ft : held_q;

  // R1: the register leaves reset in the no-match state
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !held_q);
endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tagcmp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ft_mode_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              out_en_i,
  input  logic              din_en_i,
  input  logic              mat_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              match_o,
  output logic              match_oe_o
);
  op_e               cur_op;
  op_e               s1_op;
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] p_q;
  logic              p_read;
  logic              ar_we;
  logic [DATA_W-1:0] ar_wdata;
  logic              match_held;

  tagcmp_decode u_dec (
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .out_en_i (out_en_i),
    .din_en_i (din_en_i),
    .op_o     (cur_op)
  );

  assign ar_we    = !rst && (cur_op == OP_WRITE || cur_op == OP_FILL);
  assign ar_wdata = (cur_op == OP_FILL) ? din_q : wdata_i;

  tagcmp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk     (clk),
    .we_i    (ar_we),
    .addr_i  (addr_i),
    .wdata_i (ar_wdata),
    .rdata_o (rd_q)
  );

  // key / data input register
  always_ff @(posedge clk) begin
    if (rst)
      din_q <= '0;
    else if (din_en_i)
      din_q <= wdata_i;
  end

  // first stage: operation that produced rd_q
  always_ff @(posedge clk) begin
    if (rst)
      s1_op <= OP_IDLE;
    else
      s1_op <= cur_op;
  end

  // second stage: pipelined data output
  always_ff @(posedge clk) begin
    p_q <= rd_q;
    if (rst)
      p_read <= 1'b0;
    else
      p_read <= (s1_op == OP_READ);
  end

  tagcmp_match #(.DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .ft_mode_i (ft_mode_i),
    .op_i      (s1_op),
    .stored_i  (rd_q),
    .key_i     (din_q),
    .match_o   (match_o),
    .held_o    (match_held)
  );

  assign rdata_o    = ft_mode_i ? rd_q : p_q;
  assign rdata_oe_o = out_en_i && (ft_mode_i ? (s1_op == OP_READ) : p_read);
  assign match_oe_o = mat_en_i;

  // R5: a fill leaves the registered match flag untouched
  a_r5_fill_holds: assert property (@(posedge clk) disable iff (rst)
    (sel_i && wr_i && !din_en_i) |=> ##1 $stable(match_held));

  // R6: deselect forces the match result high
  a_r6_desel_high: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> ##1 match_held);

  // R8: a compare never reaches the pipelined data stage as a read
  a_r8_cmp_no_drive: assert property (@(posedge clk) disable iff (rst)
    (sel_i && !wr_i && !out_en_i && din_en_i) |=> ##1 !p_read);

  // R10: key register only moves when its enable is set
  a_r10_key_hold: assert property (@(posedge clk) disable iff (rst)
    !din_en_i |=> $stable(din_q));
endmodule

// File: tb/tag_match_ram_tb.sv
module tag_match_ram_tb;
  localparam int CLK_P  = 10;
  localparam int AW     = 6;
  localparam int DW     = 18;
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ft_mode = 1'b1;
  logic          b_sel = 1'b0, b_wr = 1'b0, b_oe = 1'b0, b_de = 1'b0, b_men = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_wdata = '0;
  logic [DW-1:0] rdata;
  logic          rdata_oe, match, match_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string phase = "R1";

  // behavioural model state
  logic [DW-1:0] m_mem [DEPTH];
  int            m_s1_op;
  logic [DW-1:0] m_s1_q, m_pq, m_dreg;
  bit            m_hold, m_pread;

  tag_match_ram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .ft_mode_i(ft_mode), .sel_i(b_sel), .wr_i(b_wr),
    .out_en_i(b_oe), .din_en_i(b_de), .mat_en_i(b_men), .addr_i(b_addr),
    .wdata_i(b_wdata), .rdata_o(rdata), .rdata_oe_o(rdata_oe),
    .match_o(match), .match_oe_o(match_oe)
  );

  always #(CLK_P/2) clk = ~clk;

  // op codes: 0 idle, 1 deselect, 2 read, 3 write, 4 compare, 5 fill
  function automatic int op_of(bit s, bit w, bit o, bit d);
    if (!s) return 1;
    if (w) return d ? 3 : 5;
    if (!o && d) return 4;
    return 2;
  endfunction

  function automatic bit m_ft_match();
    if (m_s1_op == 4) return (m_s1_q == m_dreg);
    if (m_s1_op == 1) return 1'b1;
    return m_hold;
  endfunction

  function automatic logic [DW-1:0] pat(int a);
    return DW'((a * 32'h0000_0AB3) ^ 32'h0002_5A5A ^ (a << 11));
  endfunction

  task automatic model_edge();
    int op;
    bit n_hold, n_pread;
    logic [DW-1:0] n_pq, n_s1q;
    op = op_of(b_sel, b_wr, b_oe, b_de);
    n_hold  = m_ft_match();
    n_pq    = m_s1_q;
    n_pread = (m_s1_op == 2);
    n_s1q   = m_mem[b_addr];
    if (rst) begin
      m_hold = 0; m_pread = 0; m_s1_op = 0; m_dreg = '0;
      m_s1_q = n_s1q; m_pq = n_pq;
    end else begin
      if (op == 3) m_mem[b_addr] = b_wdata;
      if (op == 5) m_mem[b_addr] = m_dreg;
      m_hold = n_hold; m_pq = n_pq; m_pread = n_pread;
      m_s1_op = op; m_s1_q = n_s1q;
      if (b_de) m_dreg = b_wdata;
    end
  endtask

  task automatic check_outputs();
    bit e_match, e_oe;
    logic [DW-1:0] e_data;
    e_match = ft_mode ? m_ft_match() : m_hold;
    e_oe    = b_oe && (ft_mode ? (m_s1_op == 2) : m_pread);
    e_data  = ft_mode ? m_s1_q : m_pq;
    checks++;
    if (match !== e_match) begin
      fails++;
      $display("FAIL [%s] R3 match_o got %0b exp %0b (ft=%0b)", phase, match, e_match, ft_mode);
    end
    checks++;
    if (match_oe !== b_men) begin
      fails++;
      $display("FAIL [%s] R7 match_oe_o got %0b exp %0b", phase, match_oe, b_men);
    end
    checks++;
    if (rdata_oe !== e_oe) begin
      fails++;
      $display("FAIL [%s] R8 rdata_oe_o got %0b exp %0b (ft=%0b)", phase, rdata_oe, e_oe, ft_mode);
    end
    if (e_oe) begin
      checks++;
      if (rdata !== e_data) begin
        fails++;
        $display("FAIL [%s] R2 rdata_o got %h exp %h (ft=%0b)", phase, rdata, e_data, ft_mode);
      end
    end
  endtask

  // called at a falling edge; drives, clocks, models, then checks at the next falling edge
  task automatic step(bit s, bit w, bit o, bit d, bit me, int a, logic [DW-1:0] wd);
    b_sel = s; b_wr = w; b_oe = o; b_de = d; b_men = me;
    b_addr = AW'(a); b_wdata = wd;
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    check_outputs();
  endtask

  task automatic nop();      step(1, 0, 0, 0, 1, 0, '0); endtask
  task automatic rd(int a);  step(1, 0, 1, 0, 1, a, '0); endtask
  task automatic wr(int a, logic [DW-1:0] v); step(1, 1, 0, 1, 1, a, v); endtask
  task automatic cmp(int a, logic [DW-1:0] k); step(1, 0, 0, 1, 1, a, k); endtask
  task automatic fill(int a); step(1, 1, 0, 0, 1, a, '1); endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_s1_op = 0; m_hold = 0; m_pread = 0; m_dreg = '0; m_s1_q = '0; m_pq = '0;
    @(negedge clk);
    rst = 1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, '0);
    rst = 0;
    // R1: reset state observed in both modes
    phase = "R1";
    ft_mode = 1; nop();
    ft_mode = 0; nop();
    ft_mode = 1;

    phase = "R2";
    for (int i = 0; i < DEPTH; i++) wr(i, pat(i));
    rd(3); rd(4); rd(5); nop();
    phase = "R4";
    ft_mode = 0;
    rd(3); rd(4); rd(5); nop(); nop();

    // R9: hit, miss on top bit, fill, hit again, flow-through
    phase = "R9";
    ft_mode = 1;
    cmp(10, pat(10));
    cmp(11, pat(11) ^ (DW'(1) << (DW-1)));
    fill(11);
    cmp(11, pat(11) ^ (DW'(1) << (DW-1)));
    rd(11); nop();
    // R3: single low-bit difference, pipelined
    phase = "R3";
    ft_mode = 0;
    cmp(20, pat(20));
    cmp(21, pat(21) ^ DW'(1));
    fill(21);
    cmp(21, pat(21) ^ DW'(1));
    nop(); rd(21); nop(); nop();

    // R6: deselect forces match high
    phase = "R6";
    ft_mode = 1;
    cmp(22, ~pat(22));
    step(0, 0, 0, 0, 1, 0, '0);
    cmp(22, ~pat(22));
    ft_mode = 0;
    step(0, 1, 1, 1, 1, 5, '0);
    nop(); nop();

    // R7: match enable toggled independently
    phase = "R7";
    step(1, 0, 0, 1, 0, 23, pat(23));
    step(1, 0, 0, 0, 1, 0, '0);
    step(1, 0, 1, 0, 0, 23, '0);

    // R10: key kept across a read with input enable low, then filled
    phase = "R10";
    ft_mode = 1;
    cmp(30, DW'(18'h1_2345));
    step(1, 0, 1, 0, 1, 31, DW'(18'h3_FFFF));
    fill(30);
    rd(30); nop();

    // R5: fill holds the flag in both modes
    phase = "R5";
    cmp(40, pat(40)); fill(41); nop();
    ft_mode = 0;
    cmp(42, ~pat(42)); fill(43); nop(); nop();

    // random mix compared against the model every cycle
    phase = "R8";
    for (int i = 0; i < 800; i++) begin
      if (i % 100 == 0) ft_mode = ~ft_mode;
      step(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % 2,
           ($urandom % 4) != 0, $urandom % DEPTH,
           ($urandom % 2) ? pat($urandom % DEPTH) : DW'($urandom));
    end
    nop(); nop();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL [%s] watchdog expired got running exp finished", phase);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule